// File: doc/BRIEF.md
# Video Sync Output Aligner

This block is the last stage before the output pads of a video decoder. On every pixel clock it takes six timing strobes (horizontal sync, horizontal clamp, active video, vertical sync, a helper strobe and an interlace flag) and one luma byte and one chroma byte. It passes them to registered outputs after a fixed pipeline delay. The active-video strobe can be made to arrive 0 to 3 clocks ahead of the pixel data it frames, so that a downstream capture device can prepare before the first valid sample.

Each timing output has its own programmable polarity. A separate pin-control word sets the output-enable signals for the pad groups. For the sync and clock groups a set bit turns the drivers off. For the data groups a set bit turns the drivers on.

A change to the lead setting waits for a clean start of a new active-video strobe. A strobe that is already in flight is therefore never cut short or emitted twice.

Top module: `sync_out_align`

## Requirements
- R1: `luma_o` and `chroma_o` equal `luma_i` and `chroma_i` from exactly 4 clocks earlier. This delay is a 3-clock line plus the output register.
- R2: `actv_o` follows `actv_i` (before inversion) with a delay of 4 − L clocks. L is the applied lead: `sync_ctrl_i[1:0]` = 00 gives 0, 01 gives 1, 10 gives 2 and 11 gives 3. The other five timing outputs always use the 4-clock delay.
- R3: `sync_ctrl_i` is captured one clock before use. A newly captured lead value is applied only on a clock where `actv_i` is 1 and was 0 on each of the three preceding clocks (or on each clock since reset, if fewer). Otherwise the previously applied lead stays in force.
- R4: bits 2, 3, 4, 5, 6 and 7 of `sync_ctrl_i` invert `hsync_o`, `hclamp_o`, `actv_o`, `vsync_o`, `help_o` and `ilace_o` respectively: 1 inverts and 0 passes the strobe through. A polarity setting shows at the outputs on the second clock after it is presented.
- R5: one clock after `pin_ctrl_i` is sampled, `actv_oe_o` is the inverse of bit 3 and `sync_oe_o` (the other five timing pins) is the inverse of bit 4.
- R6: one clock after sampling, `llc1_oe_o`, `llc2_oe_o` and `fifo_oe_o` are the inverses of `pin_ctrl_i` bits 6, 7 and 9.
- R7: one clock after sampling, `chroma_oe_o` equals `pin_ctrl_i` bit 10 and `luma_oe_o` equals bit 11. Here a set bit enables the driver.
- R8: `pin_ctrl_i` bits 0, 1, 2, 5, 8 and 12 to 15 have no effect on any output.
- R9: while `rst_n` is low, all timing and data outputs are 0, the applied lead is 0, `actv_oe_o`, `sync_oe_o`, `llc1_oe_o`, `llc2_oe_o` and `fifo_oe_o` are 1, and `chroma_oe_o` and `luma_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_ctrl_i | input | 8 | Lead field [1:0] and per-strobe polarity bits [7:2] |
| pin_ctrl_i | input | 16 | Output-enable control word |
| hsync_i | input | 1 | Horizontal sync strobe |
| hclamp_i | input | 1 | Horizontal clamp strobe |
| actv_i | input | 1 | Active-video strobe |
| vsync_i | input | 1 | Vertical sync strobe |
| help_i | input | 1 | Helper strobe |
| ilace_i | input | 1 | Interlace field flag |
| luma_i | input | 8 | Luma sample |
| chroma_i | input | 8 | Chroma sample |
| hsync_o | output | 1 | Delayed, polarity-adjusted horizontal sync |
| hclamp_o | output | 1 | Delayed, polarity-adjusted horizontal clamp |
| actv_o | output | 1 | Lead-adjusted, polarity-adjusted active video |
| vsync_o | output | 1 | Delayed, polarity-adjusted vertical sync |
| help_o | output | 1 | Delayed, polarity-adjusted helper strobe |
| ilace_o | output | 1 | Delayed, polarity-adjusted interlace flag |
| luma_o | output | 8 | Delayed luma sample |
| chroma_o | output | 8 | Delayed chroma sample |
| actv_oe_o | output | 1 | Enable for the active-video pad |
| sync_oe_o | output | 1 | Enable for the other timing pads |
| llc1_oe_o | output | 1 | Enable for the first line-locked clock pad |
| llc2_oe_o | output | 1 | Enable for the second line-locked clock pad |
| fifo_oe_o | output | 1 | Enable for the FIFO control pads |
| chroma_oe_o | output | 1 | Enable for the chroma data pads |
| luma_oe_o | output | 1 | Enable for the luma data pads |

## Verification
Each result has its own due time:
- Data and the five non-leading strobes are due 4 clocks after their inputs.
- Active video is due 4 − L clocks after its input, where L only changes on a qualifying rising edge.
- Polarity settings are due 2 clocks after they are presented.
- Pin enables are due 1 clock after they are presented.

The bench keeps a behavioural history of the inputs and the captured controls and advances it on each rising edge. It compares every output against that history on the following falling edge, so each expected value is taken from exactly the cycle in which the registered output is due. Strobe gaps shorter than three clocks are applied on purpose, to confirm that a pending lead change is held back until a quiet gap appears.

// File: rtl/vso_pkg.sv
package vso_pkg;

    localparam int SYNC_N = 6;
    localparam int LEAD_W = 2;
    localparam int PIN_W  = 16;

    // pin-control bit positions decoded by the enable stage
    localparam int PIN_AV_OFF   = 3;
    localparam int PIN_SYNC_OFF = 4;
    localparam int PIN_LLC1_OFF = 6;
    localparam int PIN_LLC2_OFF = 7;
    localparam int PIN_FIFO_OFF = 9;
    localparam int PIN_C_ON     = 10;
    localparam int PIN_Y_ON     = 11;

    // timing strobes; hs sits at bit 0 so the polarity field maps directly
    typedef struct packed {
        logic ilace;
        logic help;
        logic vs;
        logic av;
        logic hc;
        logic hs;
    } sync_t;

    // sync-control word: polarity bits above the lead field
    typedef struct packed {
        sync_t             inv;
        logic [LEAD_W-1:0] lead;
    } sync_ctrl_t;

    typedef struct packed {
        logic av;
        logic sync;
        logic llc1;
        logic llc2;
        logic fifo;
        logic chroma;
        logic luma;
    } oe_t;

    localparam oe_t OE_RST = '{av: 1'b1, sync: 1'b1, llc1: 1'b1, llc2: 1'b1,
                               fifo: 1'b1, chroma: 1'b0, luma: 1'b0};

endpackage

// File: rtl/vso_tap_line.sv
module vso_tap_line #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            din,
    output logic [DEPTH:0][W-1:0]   taps
);

    logic [DEPTH-1:0][W-1:0] stage_d;
    logic [DEPTH-1:0][W-1:0] stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // tap 0 is the undelayed input, tap k is k clocks old
    assign taps[0] = din;
    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        assign taps[g+1] = stage_q[g];
    end

endmodule

// File: rtl/vso_lead_ctrl.sv
module vso_lead_ctrl #(
    parameter int LEAD_W = 2,
    parameter int HIST   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEAD_W-1:0] lead_req,
    input  logic              strobe_now,
    input  logic [HIST-1:0]   strobe_hist,
    output logic [LEAD_W-1:0] lead_q
);

    logic [LEAD_W-1:0] lead_d;
    logic              quiet;

    // switch only where the whole delay line holds no part of a strobe
    always_comb begin
        quiet  = (strobe_hist == '0);
        lead_d = lead_q;
        if (strobe_now && quiet) begin
            lead_d = lead_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q <= '0;
        end else begin
            lead_q <= lead_d;
        end
    end

endmodule

// File: rtl/vso_pin_oe.sv
module vso_pin_oe
    import vso_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pin_ctrl,
    output oe_t              oe_q
);

    oe_t oe_d;

    always_comb begin
        // timing and clock groups: a set bit releases the pin
        oe_d.av     = ~pin_ctrl[PIN_AV_OFF];
        oe_d.sync   = ~pin_ctrl[PIN_SYNC_OFF];
        oe_d.llc1   = ~pin_ctrl[PIN_LLC1_OFF];
        oe_d.llc2   = ~pin_ctrl[PIN_LLC2_OFF];
        oe_d.fifo   = ~pin_ctrl[PIN_FIFO_OFF];
        // data groups: a set bit drives the pin
        oe_d.chroma = pin_ctrl[PIN_C_ON];
        oe_d.luma   = pin_ctrl[PIN_Y_ON];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= OE_RST;
        end else begin
            oe_q <= oe_d;
        end
    end

endmodule

// File: rtl/sync_out_align.sv
module sync_out_align
    import vso_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sync_ctrl_i,
    input  logic [15:0]       pin_ctrl_i,
    input  logic              hsync_i,
    input  logic              hclamp_i,
    input  logic              actv_i,
    input  logic              vsync_i,
    input  logic              help_i,
    input  logic              ilace_i,
    input  logic [DATA_W-1:0] luma_i,
    input  logic [DATA_W-1:0] chroma_i,
    output logic              hsync_o,
    output logic              hclamp_o,
    output logic              actv_o,
    output logic              vsync_o,
    output logic              help_o,
    output logic              ilace_o,
    output logic [DATA_W-1:0] luma_o,
    output logic [DATA_W-1:0] chroma_o,
    output logic              actv_oe_o,
    output logic              sync_oe_o,
    output logic              llc1_oe_o,
    output logic              llc2_oe_o,
    output logic              fifo_oe_o,
    output logic              chroma_oe_o,
    output logic              luma_oe_o
);

    localparam int MAX_LEAD = (1 << LEAD_W) - 1;
    localparam int LINE_W   = 2 * DATA_W + SYNC_N;

    typedef struct packed {
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] c;
        sync_t             s;
    } line_t;

    typedef struct packed {
        sync_ctrl_t        ctrl;
        sync_t             sync;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] c;
    } out_st_t;

    out_st_t                      st_d;
    out_st_t                      st_q;
    line_t                        line_in;
    logic [MAX_LEAD:0][LINE_W-1:0] taps;
    logic [MAX_LEAD-1:0]          strobe_hist;
    logic [LEAD_W-1:0]            lead_q;
    logic [LEAD_W-1:0]            tap_sel;
    line_t                        late;
    line_t                        pick;
    sync_t                        raw;
    oe_t                          oe_q;

    assign line_in = '{y: luma_i, c: chroma_i,
                       s: '{ilace: ilace_i, help: help_i, vs: vsync_i,
                            av: actv_i, hc: hclamp_i, hs: hsync_i}};

    vso_tap_line #(
        .W     (LINE_W),
        .DEPTH (MAX_LEAD)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .taps  (taps)
    );

    // active-video history held in the line, oldest at the top
    for (genvar g = 0; g < MAX_LEAD; g++) begin : g_hist
        line_t tap_v;
        assign tap_v          = taps[g+1];
        assign strobe_hist[g] = tap_v.s.av;
    end

    vso_lead_ctrl #(
        .LEAD_W (LEAD_W),
        .HIST   (MAX_LEAD)
    ) u_lead (
        .clk         (clk),
        .rst_n       (rst_n),
        .lead_req    (st_q.ctrl.lead),
        .strobe_now  (actv_i),
        .strobe_hist (strobe_hist),
        .lead_q      (lead_q)
    );

    vso_pin_oe u_oe (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_ctrl (pin_ctrl_i),
        .oe_q     (oe_q)
    );

    always_comb begin
        tap_sel = LEAD_W'(MAX_LEAD) - lead_q;
        late    = taps[MAX_LEAD];
        pick    = taps[tap_sel];
        raw     = late.s;
        raw.av  = pick.s.av;

        st_d.ctrl = sync_ctrl_t'(sync_ctrl_i);
        st_d.sync = sync_t'(raw ^ st_q.ctrl.inv);
        st_d.y    = late.y;
        st_d.c    = late.c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync_o     = st_q.sync.hs;
    assign hclamp_o    = st_q.sync.hc;
    assign actv_o      = st_q.sync.av;
    assign vsync_o     = st_q.sync.vs;
    assign help_o      = st_q.sync.help;
    assign ilace_o     = st_q.sync.ilace;
    assign luma_o      = st_q.y;
    assign chroma_o    = st_q.c;
    assign actv_oe_o   = oe_q.av;
    assign sync_oe_o   = oe_q.sync;
    assign llc1_oe_o   = oe_q.llc1;
    assign llc2_oe_o   = oe_q.llc2;
    assign fifo_oe_o   = oe_q.fifo;
    assign chroma_oe_o = oe_q.chroma;
    assign luma_oe_o   = oe_q.luma;

endmodule

// File: rtl/vso_align_chk.sv
module vso_align_chk #(
    parameter int DATA_W = 8,
    parameter int LEAD_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        sync_ctrl_i,
    input logic [15:0]       pin_ctrl_i,
    input logic              hsync_i,
    input logic              actv_i,
    input logic [DATA_W-1:0] luma_i,
    input logic [DATA_W-1:0] chroma_i,
    input logic              hsync_o,
    input logic [DATA_W-1:0] luma_o,
    input logic [DATA_W-1:0] chroma_o,
    input logic              llc1_oe_o,
    input logic              chroma_oe_o,
    input logic [LEAD_W-1:0] lead_q
);

    localparam int LAT = (1 << LEAD_W);

    logic [3:0] age_q;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 4'hF) begin
            age_q <= age_q + 4'd1;
        end
    end

    assign armed = (age_q > 4'(LAT));

    // R1
    data_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (luma_o == $past(luma_i, LAT)) && (chroma_o == $past(chroma_i, LAT)));

    // R4
    hs_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> hsync_o == ($past(hsync_i, LAT) ^ $past(sync_ctrl_i[2], 2)));

    // R3
    lead_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (lead_q != $past(lead_q))) |-> ($past(actv_i) && !$past(actv_i, 2)));

    // R6
    llc1_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> llc1_oe_o == !$past(pin_ctrl_i[6]));

    // R7
    chroma_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> chroma_oe_o == $past(pin_ctrl_i[10]));

endmodule

bind sync_out_align vso_align_chk #(
    .DATA_W (DATA_W),
    .LEAD_W (vso_pkg::LEAD_W)
) u_align_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_ctrl_i (sync_ctrl_i),
    .pin_ctrl_i  (pin_ctrl_i),
    .hsync_i     (hsync_i),
    .actv_i      (actv_i),
    .luma_i      (luma_i),
    .chroma_i    (chroma_i),
    .hsync_o     (hsync_o),
    .luma_o      (luma_o),
    .chroma_o    (chroma_o),
    .llc1_oe_o   (llc1_oe_o),
    .chroma_oe_o (chroma_oe_o),
    .lead_q      (lead_q)
);

// File: tb/test_sync_out_align.sv
`timescale 1ns/1ps
module test_sync_out_align;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sync_ctrl_i = '0;
    logic [15:0] pin_ctrl_i = '0;
    logic        hsync_i = 0, hclamp_i = 0, actv_i = 0, vsync_i = 0, help_i = 0, ilace_i = 0;
    logic [7:0]  luma_i = '0, chroma_i = '0;
    logic        hsync_o, hclamp_o, actv_o, vsync_o, help_o, ilace_o;
    logic [7:0]  luma_o, chroma_o;
    logic        actv_oe_o, sync_oe_o, llc1_oe_o, llc2_oe_o, fifo_oe_o, chroma_oe_o, luma_oe_o;

    always #2.5 clk = ~clk;

    sync_out_align i_sync_out_align (
        .clk(clk), .rst_n(rst_n), .sync_ctrl_i(sync_ctrl_i), .pin_ctrl_i(pin_ctrl_i),
        .hsync_i(hsync_i), .hclamp_i(hclamp_i), .actv_i(actv_i), .vsync_i(vsync_i),
        .help_i(help_i), .ilace_i(ilace_i), .luma_i(luma_i), .chroma_i(chroma_i),
        .hsync_o(hsync_o), .hclamp_o(hclamp_o), .actv_o(actv_o), .vsync_o(vsync_o),
        .help_o(help_o), .ilace_o(ilace_o), .luma_o(luma_o), .chroma_o(chroma_o),
        .actv_oe_o(actv_oe_o), .sync_oe_o(sync_oe_o), .llc1_oe_o(llc1_oe_o),
        .llc2_oe_o(llc2_oe_o), .fifo_oe_o(fifo_oe_o), .chroma_oe_o(chroma_oe_o),
        .luma_oe_o(luma_oe_o)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string phase = "R9";
    bit    chk_on = 0;

    // behavioural reference: input history words {y, c, ilace, help, vs, av, hc, hs}
    logic [21:0] h1 = '0, h2 = '0, h3 = '0, cur;
    logic [7:0]  m_ctrl = '0;
    logic [1:0]  m_lead = '0;
    logic [5:0]  m_sync = '0, nsync;
    logic [7:0]  m_y = '0, m_c = '0;
    logic [6:0]  m_oe = 7'b1111100;   // {av, sync, llc1, llc2, fifo, chroma, luma}
    logic        av_src;
    int          sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = '0; h2 = '0; h3 = '0;
            m_ctrl = '0; m_lead = '0; m_sync = '0; m_y = '0; m_c = '0;
            m_oe = 7'b1111100;
        end else begin
            cur = {luma_i, chroma_i, ilace_i, help_i, vsync_i, actv_i, hclamp_i, hsync_i};
            sel = 3 - int'(m_lead);
            case (sel)
                0: av_src = cur[2];
                1: av_src = h1[2];
                2: av_src = h2[2];
                default: av_src = h3[2];
            endcase
            nsync    = h3[5:0];
            nsync[2] = av_src;
            m_sync   = nsync ^ m_ctrl[7:2];
            m_y      = h3[21:14];
            m_c      = h3[13:6];
            if (cur[2] && !h1[2] && !h2[2] && !h3[2]) m_lead = m_ctrl[1:0];
            m_oe = {~pin_ctrl_i[3], ~pin_ctrl_i[4], ~pin_ctrl_i[6], ~pin_ctrl_i[7],
                    ~pin_ctrl_i[9], pin_ctrl_i[10], pin_ctrl_i[11]};
            h3 = h2; h2 = h1; h1 = cur;
            m_ctrl = sync_ctrl_i;
        end
    end

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: got %0h expected %0h at %0t", tag, phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R1", "luma_o", luma_o, m_y);
            chk("R1", "chroma_o", chroma_o, m_c);
            chk("R2", "actv_o", {7'd0, actv_o}, {7'd0, m_sync[2]});
            chk("R4", "hsync_o", {7'd0, hsync_o}, {7'd0, m_sync[0]});
            chk("R4", "hclamp_o", {7'd0, hclamp_o}, {7'd0, m_sync[1]});
            chk("R4", "vsync_o", {7'd0, vsync_o}, {7'd0, m_sync[3]});
            chk("R4", "help_o", {7'd0, help_o}, {7'd0, m_sync[4]});
            chk("R4", "ilace_o", {7'd0, ilace_o}, {7'd0, m_sync[5]});
            chk("R5", "actv/sync oe", {6'd0, actv_oe_o, sync_oe_o}, {6'd0, m_oe[6:5]});
            chk("R6", "llc1/llc2/fifo oe", {5'd0, llc1_oe_o, llc2_oe_o, fifo_oe_o}, {5'd0, m_oe[4:2]});
            chk("R7", "chroma/luma oe", {6'd0, chroma_oe_o, luma_oe_o}, {6'd0, m_oe[1:0]});
        end
    end

    task automatic step(input logic av);
        @(negedge clk);
        #1;
        actv_i   = av;
        hsync_i  = 1'($urandom);
        hclamp_i = 1'($urandom);
        vsync_i  = 1'($urandom);
        help_i   = 1'($urandom);
        ilace_i  = 1'($urandom);
        luma_i   = 8'($urandom);
        chroma_i = 8'($urandom);
    endtask

    task automatic line(input int gap, input int len);
        for (int i = 0; i < gap; i++) step(1'b0);
        for (int i = 0; i < len; i++) step(1'b1);
    endtask

    initial begin
        // R9: reset state
        @(posedge clk);
        chk_on = 1;
        repeat (4) step(1'b0);
        rst_n = 1'b1;

        // R1, R2: lead 0
        phase = "R2 lead0";
        for (int k = 0; k < 6; k++) line(4, 6);

        // R2: each lead value, quiet gaps
        for (int ld = 1; ld < 4; ld++) begin
            phase = "R2 lead sweep";
            sync_ctrl_i = 8'(ld);
            for (int k = 0; k < 5; k++) line(5, 4);
        end

        // R3: changes requested while gaps are too short to qualify
        phase = "R3 deferred";
        sync_ctrl_i = 8'd1;
        for (int k = 0; k < 6; k++) line(1 + (k % 2), 3);
        line(4, 5);
        sync_ctrl_i = 8'd2;
        line(0, 4);
        for (int k = 0; k < 4; k++) line(2, 2);
        line(3, 3);
        sync_ctrl_i = 8'd0;
        line(0, 6);
        line(6, 2);

        // R4: each polarity bit alone, then all
        for (int b = 2; b < 8; b++) begin
            phase = "R4 polarity";
            sync_ctrl_i = 8'(1 << b) | 8'd2;
            for (int k = 0; k < 3; k++) line(4, 3);
        end
        sync_ctrl_i = 8'hFD;
        for (int k = 0; k < 3; k++) line(4, 3);

        // R5, R6, R7, R8: walk each pin-control bit
        for (int b = 0; b < 16; b++) begin
            if (b == 0 || b == 1 || b == 2 || b == 5 || b == 8 || b >= 12) phase = "R8 reserved";
            else phase = "R5-R7 pins";
            pin_ctrl_i = 16'(1 << b);
            line(3, 3);
        end
        phase = "R8 reserved";
        pin_ctrl_i = 16'hF127;
        line(4, 6);
        pin_ctrl_i = 16'h0ED8;
        phase = "R5-R7 pins";
        line(4, 6);

        // mixed traffic
        phase = "R3 mixed";
        for (int k = 0; k < 400; k++) begin
            if (k % 7 == 0) sync_ctrl_i = 8'($urandom);
            if (k % 5 == 0) pin_ctrl_i = 16'($urandom);
            line($urandom_range(0, 6), $urandom_range(1, 8));
        end

        @(negedge clk);
        #1;
        chk_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule